// File: doc/BRIEF.md
# Bit-Sliced Parallel PRBS Generator

This block produces a byte-wide pseudo-random test pattern, one byte per clock, for exercising a parallel data link. Eight small 5-bit linear feedback shift registers run side by side. Each register drives exactly one bit of the output byte through its most significant bit. Every register starts from a window of one shared seed byte. The byte stream repeats every 31 words.

The same block serves at both ends of a link test. On the sending side it is the pattern source. On the receiving side a second, identical copy is started once incoming data is seen, and it then supplies the expected words for comparison. The generators hold their state while the enable level is low. A copy started later therefore still begins at the first word of the sequence and stays in step with the sender. While idle the output byte is zero. A registered flag shows whether the byte currently on the output is pattern data.

Top module: `prbs_slice_gen`

## Requirements
- R1: While reset is asserted, and in the cycles after its release until enable is first sampled high, `word_o` is 8'h00 and `active_o` is 0; reset loads every shift register with its seed window.
- R2: The generator has eight 5-bit shift registers with polynomial x^5 + x^3 + 1 in Fibonacci form. On each step a register shifts left, and bit 0 takes bit 4 XOR bit 2. Bit i of the pattern word is bit 4 of register i.
- R3: The seed byte is 8'h47. Bit k of register i is loaded from seed bit (i+k) mod 8, so the first pattern word after reset is 8'h74.
- R4: Each clock edge with `run_en_i` high advances every register by one step. The word formed from the state before that step appears on `word_o` after that same edge.
- R5: While enabled, the word stream is periodic with period 31: word n+31 equals word n.
- R6: A clock edge with `run_en_i` low leaves all register states unchanged, so the stream resumes with the word that would have come next.
- R7: After a clock edge with `run_en_i` low, `word_o` is 8'h00.
- R8: `active_o` equals the value of `run_en_i` at the previous clock edge.
- R9: Two instances released from reset together produce the same word stream, offset by exactly the number of cycles between their enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| run_en_i | input | 1 | Run level; high advances the pattern one word per clock |
| word_o | output | 8 | Registered pattern byte, zero while idle |
| active_o | output | 1 | Registered run flag, `run_en_i` delayed one clock |

## Verification
Both outputs are due exactly one clock edge after `run_en_i` is sampled: the word for a given state and the matching flag appear together after the edge that sampled enable high, and the zero word and cleared flag appear after the edge that sampled it low. The bench changes enable on the falling edge. It computes the expected word from its own model of the eight registers before that model steps, then reads both outputs on the next falling edge, half a cycle after the register update. The period and dual-instance checks record the outputs cycle by cycle and compare the recorded words at offsets of 31 cycles and of the enable delay.

// File: rtl/prbs_slice_pkg.sv
package prbs_slice_pkg;

  localparam int unsigned DEF_LANES  = 8;
  localparam int unsigned DEF_LFSR_W = 5;
  localparam logic [7:0]  DEF_SEED   = 8'h47;
  // feedback taps: bits 4 and 2 of the state (x^5 + x^3 + 1)
  localparam logic [4:0]  DEF_TAPS   = 5'b10100;

  // circular window of the seed, starting at bit 'lane', win_w bits long
  function automatic logic [31:0] seed_window(
    input logic [63:0] seed,
    input int unsigned seed_w,
    input int unsigned lane,
    input int unsigned win_w
  );
    logic [31:0] r;
    r = '0;
    for (int unsigned k = 0; k < win_w; k++) begin
      r[k] = seed[(lane + k) % seed_w];
    end
    return r;
  endfunction

endpackage

// File: rtl/prbs_lfsr_lane.sv
module prbs_lfsr_lane #(
  parameter int unsigned     W    = 5,
  parameter logic [W-1:0]    TAPS = 5'b10100,
  parameter logic [W-1:0]    INIT = 5'b00111
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o,
  output logic         msb_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb;

  always_comb begin
    fb      = ^(state_q & TAPS);
    state_d = state_q;
    if (step_i) begin
      state_d = {state_q[W-2:0], fb};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= INIT;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;
  assign msb_o   = state_q[W-1];

endmodule

// File: rtl/prbs_word_reg.sv
module prbs_word_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] word_o,
  output logic         active_o
);

  logic [N-1:0] word_q;
  logic [N-1:0] word_d;
  logic         active_q;
  logic         active_d;

  always_comb begin
    word_d   = en_i ? bits_i : '0;
    active_d = en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q   <= '0;
      active_q <= 1'b0;
    end else begin
      word_q   <= word_d;
      active_q <= active_d;
    end
  end

  assign word_o   = word_q;
  assign active_o = active_q;

endmodule

// File: rtl/prbs_slice_gen.sv
module prbs_slice_gen #(
  parameter int unsigned          LANES  = prbs_slice_pkg::DEF_LANES,
  parameter int unsigned          LFSR_W = prbs_slice_pkg::DEF_LFSR_W,
  parameter logic [LANES-1:0]     SEED   = prbs_slice_pkg::DEF_SEED,
  parameter logic [LFSR_W-1:0]    TAPS   = prbs_slice_pkg::DEF_TAPS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  output logic [LANES-1:0] word_o,
  output logic             active_o
);

  localparam int unsigned STATE_BITS = LANES * LFSR_W;

  logic [LANES-1:0]      lane_msb;
  logic [STATE_BITS-1:0] lane_state;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LFSR_W-1:0] LANE_INIT =
      LFSR_W'(prbs_slice_pkg::seed_window(64'(SEED), LANES, g, LFSR_W));

    prbs_lfsr_lane #(
      .W    (LFSR_W),
      .TAPS (TAPS),
      .INIT (LANE_INIT)
    ) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (run_en_i),
      .state_o (lane_state[g*LFSR_W +: LFSR_W]),
      .msb_o   (lane_msb[g])
    );
  end

  prbs_word_reg #(
    .N (LANES)
  ) u_word (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (run_en_i),
    .bits_i   (lane_msb),
    .word_o   (word_o),
    .active_o (active_o)
  );

endmodule

// File: rtl/prbs_slice_gen_chk.sv
module prbs_slice_gen_chk #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LFSR_W = 5
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    run_en_i,
  input logic [LANES-1:0]        word_o,
  input logic                    active_o,
  input logic [LANES*LFSR_W-1:0] lane_state
);

  // R7: an idle output carries no pattern bits
  p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (word_o == '0));

  // R8: run flag follows enable by one edge
  p_flag_delay_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (active_o == $past(run_en_i)));

  // R6: no state movement while enable is low
  p_hold_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |=> $stable(lane_state));

  // R4: every enabled edge moves the state
  p_step_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_en_i |=> (lane_state != $past(lane_state)));

  // R2: a maximal-length register never reaches the all-zero lock-up state
  for (genvar g = 0; g < LANES; g++) begin : g_nz
    p_lane_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lane_state[g*LFSR_W +: LFSR_W] != '0);
  end

endmodule

bind prbs_slice_gen prbs_slice_gen_chk #(
  .LANES  (LANES),
  .LFSR_W (LFSR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_en_i   (run_en_i),
  .word_o     (word_o),
  .active_o   (active_o),
  .lane_state (lane_state)
);

// File: tb/prbs_slice_gen_tb.sv
module prbs_slice_gen_tb;

  localparam logic [7:0] SEED  = 8'h47;
  localparam int         NVEC  = 6;
  localparam int         DELAY = 4;
  // each entry: {enabled cycles, idle cycles}
  localparam int VEC [NVEC][2] = '{'{1, 1}, '{5, 3}, '{31, 2}, '{2, 7}, '{40, 1}, '{3, 4}};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_a, en_b;
  logic [7:0] word_a, word_b;
  logic       act_a, act_b;

  int n_tests = 0;
  int n_fail  = 0;

  logic [4:0] mdl [8];
  logic [7:0] rec [80];

  always #5 clk = ~clk;

  prbs_slice_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_en_i(en_a), .word_o(word_a), .active_o(act_a)
  );

  prbs_slice_gen u_twin (
    .clk_i(clk), .rst_ni(rst_n), .run_en_i(en_b), .word_o(word_b), .active_o(act_b)
  );

  task automatic mdl_seed();
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 5; k++)
        mdl[i][k] = SEED[(i + k) % 8];
  endtask

  function automatic logic [7:0] mdl_word();
    logic [7:0] w;
    for (int i = 0; i < 8; i++) w[i] = mdl[i][4];
    return w;
  endfunction

  task automatic mdl_step();
    for (int i = 0; i < 8; i++) mdl[i] = {mdl[i][3:0], mdl[i][4] ^ mdl[i][2]};
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one clock with the given enable; checks word and flag on the next falling edge
  task automatic cycle(input logic e, input string tag);
    logic [7:0] exp_w;
    en_a  = e;
    exp_w = e ? mdl_word() : 8'h00;
    if (e) mdl_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, word_a, exp_w);
    chk({tag, " flag R8"}, {7'd0, act_a}, {7'd0, e});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en_a  = 1'b0;
    en_b  = 1'b0;
    @(negedge clk);
    chk("R1 word in reset", word_a, 8'h00);
    chk("R1 flag in reset", {7'd0, act_a}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    mdl_seed();
    @(negedge clk);
    chk("R1 word after release", word_a, 8'h00);
    chk("R1 flag after release", {7'd0, act_a}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    en_a  = 1'b0;
    en_b  = 1'b0;
    do_reset();

    // table-driven runs and pauses
    for (int v = 0; v < NVEC; v++) begin
      for (int c = 0; c < VEC[v][0]; c++)
        cycle(1'b1, (c == 0 && v > 0) ? "R6 resume" : "R2 R4 run");
      for (int c = 0; c < VEC[v][1]; c++)
        cycle(1'b0, "R7 idle");
    end

    // reset in the middle of a run, then the seeded first word
    cycle(1'b1, "R4 pre-reset");
    cycle(1'b1, "R4 pre-reset");
    do_reset();
    cycle(1'b1, "R3 first word");
    chk("R3 first word constant", word_a, 8'h74);

    // period of 31 words
    do_reset();
    for (int t = 0; t < 62; t++) begin
      cycle(1'b1, "R4 period run");
      rec[t] = word_a;
    end
    for (int t = 0; t < 31; t++) chk("R5 period", rec[t + 31], rec[t]);
    cycle(1'b0, "R7 idle after period");

    // two instances, second started DELAY cycles later
    do_reset();
    for (int t = 0; t < 50; t++) begin
      en_a = 1'b1;
      en_b = (t >= DELAY);
      @(posedge clk);
      @(negedge clk);
      rec[t] = word_a;
      if (t >= DELAY) chk("R9 twin stream", word_b, rec[t - DELAY]);
    end
    en_a = 1'b0;
    en_b = 1'b0;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule